// File: doc/BRIEF.md
# Flag-Conditioned Next-PC Unit

This block works out the address of the following instruction. Each cycle it takes the current program counter, the 7-bit opcode, two 3-bit register fields and the four stored condition flags (carry, negative, overflow, zero). From these it decides whether control leaves the sequential path. It covers the eight conditional branches, the unconditional jump and the plain step to the next word. Fetching the instruction is left to the surrounding datapath.

The opcode sorts every instruction into one of three step kinds:

- **STEP_SEQ**: any opcode whose top two bits are not both one. The result is PC + 1.
- **STEP_COND**: top three bits `110`. Bit 2 picks the polarity and bits 1..0 pick the flag.
- **STEP_JUMP**: top three bits `111`. The result is always PC + offset.

The offset is a signed value. It is made by joining the destination field (upper part) to the second-source field (lower part) and extending the sign. The kind, the condition result and the target are registered. Both outputs therefore describe the inputs presented one clock earlier.

Top module: `bru_next_pc`

## Requirements
- R1: While `rst_n` is low, `next_pc` is 0 and `taken` is 0.
- R2: An opcode whose bits 6..5 are not `11` gives `next_pc` = `pc` + 1 with `taken` low, whatever the flags and fields hold.
- R3: An opcode `110x0ss` is taken when the flag chosen by `ss` is 1. The codes are `00` carry, `01` negative, `10` overflow, `11` zero.
- R4: An opcode `110x1ss` is taken when the flag chosen by `ss` is 0, using the same `ss` encoding as R3.
- R5: Opcode bit 3 has no effect on any branch.
- R6: A taken step gives `next_pc` = `pc` + sign-extended `{dr, sb}`, with `dr` as the upper three bits and the sum taken modulo 2^16. The offset range is −32 to +31.
- R7: A step that is not taken gives `pc` + 1 modulo 2^16, so 0xFFFF is followed by 0x0000.
- R8: An opcode `111xxxx` is always taken, whatever the flags hold.
- R9: `next_pc` and `taken` show the result for the inputs present at the previous rising clock edge.
- R10: `taken` is high only for a taken conditional branch or a jump.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 7 | Instruction opcode |
| dr | input | 3 | Destination field, upper part of the offset |
| sb | input | 3 | Second-source field, lower part of the offset |
| pc | input | 16 | Current program counter |
| flag_c | input | 1 | Stored carry flag |
| flag_n | input | 1 | Stored negative flag |
| flag_v | input | 1 | Stored overflow flag |
| flag_z | input | 1 | Stored zero flag |
| next_pc | output | 16 | Registered address of the following instruction |
| taken | output | 1 | Registered flag, high when control leaves the sequential path |

## Verification
The flag test and the address wrap can act on the same cycle. In that cycle, one taken or not-taken decision must also carry the 16-bit sum across the top or bottom of the address space. The bench provokes this with program counters at 0x0000, 0xFFFF, 0xFFE0 and 0x7FFF. At those values it drives every one of the 128 opcodes against all 16 flag patterns. It then sweeps all 64 offsets at both ends of the range. Each result is judged against a sum and a flag choice that the bench computes itself.

// File: rtl/bru_pkg.sv
package bru_pkg;

    // Step kinds that the opcode decodes to
    typedef enum logic [1:0] {
        STEP_SEQ  = 2'd0,
        STEP_COND = 2'd1,
        STEP_JUMP = 2'd2
    } step_kind_e;

    // Flag chosen by the two low opcode bits of a conditional branch
    typedef enum logic [1:0] {
        FLAG_CARRY = 2'd0,
        FLAG_NEG   = 2'd1,
        FLAG_OVF   = 2'd2,
        FLAG_ZERO  = 2'd3
    } flag_sel_e;

    localparam int unsigned NUM_FLAGS = 4;

endpackage

// File: rtl/bru_decode.sv
module bru_decode
    import bru_pkg::*;
#(
    parameter int unsigned OP_W = 7
) (
    input  logic [OP_W-1:0] opcode,
    output step_kind_e      kind,
    output flag_sel_e       sel,
    output logic            invert
);

    localparam int unsigned CLS_HI = OP_W - 1;
    localparam int unsigned CLS_LO = OP_W - 3;

    logic [2:0] cls;

    assign cls    = opcode[CLS_HI:CLS_LO];
    assign invert = opcode[2];
    assign sel    = flag_sel_e'(opcode[1:0]);

    always_comb begin
        unique case (cls)
            3'b110:  kind = STEP_COND;
            3'b111:  kind = STEP_JUMP;
            default: kind = STEP_SEQ;
        endcase
    end

endmodule

// File: rtl/bru_cond.sv
module bru_cond
    import bru_pkg::*;
(
    input  step_kind_e           kind,
    input  flag_sel_e            sel,
    input  logic                 invert,
    input  logic [NUM_FLAGS-1:0] flags,
    output logic                 take
);

    logic picked;

    always_comb begin
        unique case (sel)
            FLAG_CARRY: picked = flags[0];
            FLAG_NEG:   picked = flags[1];
            FLAG_OVF:   picked = flags[2];
            FLAG_ZERO:  picked = flags[3];
        endcase
    end

    always_comb begin
        unique case (kind)
            STEP_COND: take = picked ^ invert;
            STEP_JUMP: take = 1'b1;
            default:   take = 1'b0;
        endcase
    end

endmodule

// File: rtl/bru_target.sv
module bru_target #(
    parameter int unsigned PC_W    = 16,
    parameter int unsigned FIELD_W = 3
) (
    input  logic [PC_W-1:0]    pc,
    input  logic [FIELD_W-1:0] dr,
    input  logic [FIELD_W-1:0] sb,
    input  logic               take,
    output logic [PC_W-1:0]    target
);

    localparam int unsigned OFF_W = 2 * FIELD_W;
    localparam int unsigned EXT_W = PC_W - OFF_W;

    logic [OFF_W-1:0] raw_off;
    logic [PC_W-1:0]  off_ext;
    logic [PC_W-1:0]  jump_addr;
    logic [PC_W-1:0]  step_addr;

    assign raw_off   = {dr, sb};
    assign off_ext   = {{EXT_W{raw_off[OFF_W-1]}}, raw_off};
    assign jump_addr = pc + off_ext;
    assign step_addr = pc + PC_W'(1);
    assign target    = take ? jump_addr : step_addr;

endmodule

// File: rtl/bru_next_pc.sv
module bru_next_pc
    import bru_pkg::*;
#(
    parameter int unsigned PC_W    = 16,
    parameter int unsigned FIELD_W = 3,
    parameter int unsigned OP_W    = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [OP_W-1:0]    opcode,
    input  logic [FIELD_W-1:0] dr,
    input  logic [FIELD_W-1:0] sb,
    input  logic [PC_W-1:0]    pc,
    input  logic               flag_c,
    input  logic               flag_n,
    input  logic               flag_v,
    input  logic               flag_z,
    output logic [PC_W-1:0]    next_pc,
    output logic               taken
);

    step_kind_e           kind;
    flag_sel_e            sel;
    logic                 invert;
    logic                 take;
    logic [PC_W-1:0]      target;
    logic [NUM_FLAGS-1:0] flags;

    assign flags = {flag_z, flag_v, flag_n, flag_c};

    bru_decode #(.OP_W(OP_W)) u_decode (
        .opcode (opcode),
        .kind   (kind),
        .sel    (sel),
        .invert (invert)
    );

    bru_cond u_cond (
        .kind   (kind),
        .sel    (sel),
        .invert (invert),
        .flags  (flags),
        .take   (take)
    );

    bru_target #(.PC_W(PC_W), .FIELD_W(FIELD_W)) u_target (
        .pc     (pc),
        .dr     (dr),
        .sb     (sb),
        .take   (take),
        .target (target)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            next_pc <= '0;
            taken   <= 1'b0;
        end else begin
            next_pc <= target;
            taken   <= take;
        end
    end

endmodule

// File: rtl/bru_checker.sv
module bru_checker #(
    parameter int unsigned PC_W    = 16,
    parameter int unsigned FIELD_W = 3,
    parameter int unsigned OP_W    = 7
) (
    input logic               clk,
    input logic               rst_n,
    input logic [OP_W-1:0]    opcode,
    input logic [FIELD_W-1:0] dr,
    input logic [FIELD_W-1:0] sb,
    input logic [PC_W-1:0]    pc,
    input logic               flag_c,
    input logic               flag_n,
    input logic               flag_v,
    input logic               flag_z,
    input logic [PC_W-1:0]    next_pc,
    input logic               taken
);

    localparam int unsigned OFF_W = 2 * FIELD_W;

    logic            primed;
    logic [PC_W-1:0] offset_now;
    logic [3:0]      flag_vec;
    logic            is_cond;
    logic            is_jump;
    logic            is_plain;

    assign offset_now = PC_W'($signed({dr, sb}));
    assign flag_vec   = {flag_z, flag_v, flag_n, flag_c};
    assign is_cond    = opcode[OP_W-1 -: 3] == 3'b110;
    assign is_jump    = opcode[OP_W-1 -: 3] == 3'b111;
    assign is_plain   = opcode[OP_W-1 -: 2] != 2'b11;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    AST_PLAIN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(is_plain) |-> !taken && next_pc == $past(pc) + PC_W'(1)); // R2

    AST_COND_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(is_cond) |-> taken == ($past(flag_vec[opcode[1:0]]) ^ $past(opcode[2]))); // R3 R4

    AST_TAKEN_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        primed && taken |-> next_pc == $past(pc) + $past(offset_now)); // R6

    AST_IDLE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        primed && !taken |-> next_pc == $past(pc) + PC_W'(1)); // R7

    AST_JUMP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(is_jump) |-> taken); // R8

    AST_TAKEN_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        primed && taken |-> $past(is_cond) || $past(is_jump)); // R10

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> next_pc == '0 && !taken); // R1

endmodule

bind bru_next_pc bru_checker #(.PC_W(PC_W), .FIELD_W(FIELD_W), .OP_W(OP_W)) u_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .opcode  (opcode),
    .dr      (dr),
    .sb      (sb),
    .pc      (pc),
    .flag_c  (flag_c),
    .flag_n  (flag_n),
    .flag_v  (flag_v),
    .flag_z  (flag_z),
    .next_pc (next_pc),
    .taken   (taken)
);

// File: tb/tb_bru_next_pc.sv
module tb_bru_next_pc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  opcode = '0;
    logic [2:0]  dr = '0;
    logic [2:0]  sb = '0;
    logic [15:0] pc = '0;
    logic        flag_c = 1'b0;
    logic        flag_n = 1'b0;
    logic        flag_v = 1'b0;
    logic        flag_z = 1'b0;
    logic [15:0] next_pc;
    logic        taken;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bru_next_pc dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .opcode  (opcode),
        .dr      (dr),
        .sb      (sb),
        .pc      (pc),
        .flag_c  (flag_c),
        .flag_n  (flag_n),
        .flag_v  (flag_v),
        .flag_z  (flag_z),
        .next_pc (next_pc),
        .taken   (taken)
    );

    function automatic string req_of(input logic [6:0] op);
        if (op[6:4] == 3'b111) return "R8";
        if (op[6:4] == 3'b110) return op[2] ? "R4" : "R3";
        return "R2";
    endfunction

    task automatic check(input string req, input logic [15:0] exp_pc, input logic exp_tk);
        checks++;
        if (next_pc !== exp_pc || taken !== exp_tk) begin
            errors++;
            $display("FAIL %s: next_pc=%h taken=%b expected next_pc=%h taken=%b",
                     req, next_pc, taken, exp_pc, exp_tk);
        end
    endtask

    // Drive one step and judge the registered result one edge later (R9)
    task automatic step(input logic [6:0] op, input logic [3:0] fl,
                        input logic [5:0] off, input logic [15:0] cur, input string tag);
        int          offv;
        logic        pick;
        logic        exp_tk;
        logic [15:0] exp_pc;
        @(negedge clk);
        opcode = op; {flag_z, flag_v, flag_n, flag_c} = fl;
        {dr, sb} = off; pc = cur;
        offv = (off >= 6'd32) ? int'(off) - 64 : int'(off);
        pick = fl[op[1:0]];
        if (op[6:4] == 3'b111)      exp_tk = 1'b1;
        else if (op[6:4] == 3'b110) exp_tk = op[2] ? !pick : pick;
        else                        exp_tk = 1'b0;
        exp_pc = exp_tk ? 16'((int'(cur) + offv) % 65536) : 16'((int'(cur) + 1) % 65536);
        @(negedge clk);
        check(tag.len() ? tag : req_of(op), exp_pc, exp_tk);
    endtask

    initial begin
        logic [15:0] pcs [4] = '{16'h0000, 16'hFFFF, 16'hFFE0, 16'h7FFF};
        // R1: reset state with active inputs
        opcode = 7'b1110000; pc = 16'h1234; dr = 3'd1;
        repeat (3) @(negedge clk);
        check("R1", 16'h0000, 1'b0);
        rst_n = 1'b1;
        // R2 R3 R4 R8 R10: every opcode against every flag pattern
        for (int p = 0; p < 4; p++) begin
            for (int op = 0; op < 128; op++) begin
                for (int fl = 0; fl < 16; fl++) begin
                    step(7'(op), 4'(fl), 6'((op * 5 + fl * 3 + p * 17) % 64), pcs[p], "");
                end
            end
        end
        // R5: bit 3 set and clear give the same outcome
        for (int op = 0; op < 8; op++) begin
            for (int fl = 0; fl < 16; fl++) begin
                step(7'b1100000 | 7'(op), 4'(fl), 6'd9, 16'h0100, "R5");
                step(7'b1101000 | 7'(op), 4'(fl), 6'd9, 16'h0100, "R5");
            end
        end
        // R6: every offset on a jump and a taken zero-branch, at both ends
        for (int off = 0; off < 64; off++) begin
            step(7'b1110101, 4'h0, 6'(off), 16'h0000, "R6");
            step(7'b1110101, 4'h0, 6'(off), 16'hFFFF, "R6");
            step(7'b1100011, 4'h8, 6'(off), 16'h8000, "R6");
        end
        // R7: not-taken wraps from top of the address space
        step(7'b1100000, 4'h0, 6'd31, 16'hFFFF, "R7");
        step(7'b0000010, 4'hF, 6'd32, 16'hFFFF, "R7");
        // R1: reset reasserted clears the registered outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 16'h0000, 1'b0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: expected=finish actual=hang");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule